// File: doc/BRIEF.md
# Boundary-Scan Test Access Port Controller

This block is the control core of a boundary-scan test port. A sixteen-state machine advances on each rising edge of the test clock, steered by the mode-select input, and produces the level strobes that tell external data registers when to capture, shift and update. A five-bit instruction register sits inside the block. It has a shift stage that is loaded with a fixed pattern and then scanned serially. It also has a separate output stage that holds the active instruction, and that instruction is decoded into one-hot register selects.

The external data registers supply their serial output on `dr_tdo_i`. The block routes either that bit or the least significant bit of the instruction shift stage to the test data output. The output changes on the falling edge of the test clock and is driven only while one of the two shift states is active. Three events return the controller to its reset state: an active-low asynchronous port reset, a system reset sampled on the test clock, or five consecutive rising edges with mode-select high.

Top module: `tap_ctrl`

## Requirements
- R1: While `rst_ni` is low, `state_o` reads 0 (test-logic-reset), `instr_o` reads 00001 and `tdo_o`/`tdo_en_o` are 0, at once and with no test-clock edge needed.
- R2: A rising `tck_i` edge with `sys_rst_i` high puts `state_o` at 0 and `instr_o` at 00001, whatever the state before.
- R3: Five consecutive rising edges with `tms_i` high reach state 0 from any state.
- R4: `state_o` advances on each rising edge by the standard transitions. The encoding is 0 reset, 1 run-idle, 2..8 the DR column (select, capture, shift, exit1, pause, exit2, update) and 9..15 the IR column in the same order. With `tms_i` high, select-IR goes to 0.
- R5: In state 0, `instr_o` is 00001 (IDCODE) and `sel_idcode_o` is high.
- R6: Capture-IR loads 00001 into the shift stage, so a following shift emits 1 first and then four 0s on `tdo_o`.
- R7: Each rising edge in Shift-IR moves the shift stage one bit toward `tdo_o`, and `tdi_i` enters at bit 4. The first bit shifted in reaches bit 0 after five shifts.
- R8: The rising edge that leaves Update-IR copies the shift stage into `instr_o`. Outside Update-IR and state 0, `instr_o` does not change.
- R9: Exactly one select is high. 00001 gives `sel_idcode_o`, 00010 gives `sel_sample_o`, 00000 gives `sel_extest_o`, and 11111 or any other code gives `sel_bypass_o`.
- R10: On each falling `tck_i` edge, `tdo_o` takes the shift stage's bit 0 in Shift-IR or `dr_tdo_i` in Shift-DR, and `tdo_en_o` goes high. In every other state both are 0.
- R11: `capture_dr_o`, `shift_dr_o`, `update_dr_o`, `capture_ir_o`, `shift_ir_o` and `update_ir_o` are each high exactly while `state_o` is 3, 4, 8, 10, 11 and 15 respectively.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck_i | input | 1 | Test clock |
| rst_ni | input | 1 | Asynchronous active-low port reset |
| sys_rst_i | input | 1 | System reset, sampled on rising `tck_i` |
| tms_i | input | 1 | Mode select |
| tdi_i | input | 1 | Serial data in |
| dr_tdo_i | input | 1 | Serial output of the selected data register |
| tdo_o | output | 1 | Serial data out |
| tdo_en_o | output | 1 | Output enable for `tdo_o` |
| state_o | output | 4 | Controller state code |
| instr_o | output | 5 | Active instruction |
| sel_idcode_o | output | 1 | Identification register selected |
| sel_sample_o | output | 1 | Sample/preload selected |
| sel_extest_o | output | 1 | External test selected |
| sel_bypass_o | output | 1 | Bypass selected |
| capture_dr_o | output | 1 | In Capture-DR |
| shift_dr_o | output | 1 | In Shift-DR |
| update_dr_o | output | 1 | In Update-DR |
| capture_ir_o | output | 1 | In Capture-IR |
| shift_ir_o | output | 1 | In Shift-IR |
| update_ir_o | output | 1 | In Update-IR |

## Verification
A wrong next-state entry shows on `state_o` and on the strobes one rising edge after the faulty transition, because every cycle is compared with a reference walk of the state graph. A corrupted instruction shift stage first appears on `tdo_o` half a clock after entry to Shift-IR. If the corruption stays hidden there, it reaches `instr_o` and the selects on the edge that leaves Update-IR. A wrong output-stage reset or decode shows within the same cycle, in state 0 or after any instruction load.

// File: rtl/tap_pkg.sv
package tap_pkg;

  typedef enum logic [3:0] {
    ST_TLR    = 4'd0,
    ST_RTI    = 4'd1,
    ST_SEL_DR = 4'd2,
    ST_CAP_DR = 4'd3,
    ST_SH_DR  = 4'd4,
    ST_EX1_DR = 4'd5,
    ST_PAU_DR = 4'd6,
    ST_EX2_DR = 4'd7,
    ST_UPD_DR = 4'd8,
    ST_SEL_IR = 4'd9,
    ST_CAP_IR = 4'd10,
    ST_SH_IR  = 4'd11,
    ST_EX1_IR = 4'd12,
    ST_PAU_IR = 4'd13,
    ST_EX2_IR = 4'd14,
    ST_UPD_IR = 4'd15
  } tap_state_e;

  typedef struct packed {
    logic cap_dr;
    logic sh_dr;
    logic upd_dr;
    logic cap_ir;
    logic sh_ir;
    logic upd_ir;
  } tap_strobe_t;

  function automatic tap_state_e tap_next(tap_state_e cur, logic tms);
    tap_state_e nxt;
    case (cur)
      ST_TLR:    nxt = tms ? ST_TLR    : ST_RTI;
      ST_RTI:    nxt = tms ? ST_SEL_DR : ST_RTI;
      ST_SEL_DR: nxt = tms ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: nxt = tms ? ST_EX1_DR : ST_SH_DR;
      ST_SH_DR:  nxt = tms ? ST_EX1_DR : ST_SH_DR;
      ST_EX1_DR: nxt = tms ? ST_UPD_DR : ST_PAU_DR;
      ST_PAU_DR: nxt = tms ? ST_EX2_DR : ST_PAU_DR;
      ST_EX2_DR: nxt = tms ? ST_UPD_DR : ST_SH_DR;
      ST_UPD_DR: nxt = tms ? ST_SEL_DR : ST_RTI;
      ST_SEL_IR: nxt = tms ? ST_TLR    : ST_CAP_IR;
      ST_CAP_IR: nxt = tms ? ST_EX1_IR : ST_SH_IR;
      ST_SH_IR:  nxt = tms ? ST_EX1_IR : ST_SH_IR;
      ST_EX1_IR: nxt = tms ? ST_UPD_IR : ST_PAU_IR;
      ST_PAU_IR: nxt = tms ? ST_EX2_IR : ST_PAU_IR;
      ST_EX2_IR: nxt = tms ? ST_UPD_IR : ST_SH_IR;
      ST_UPD_IR: nxt = tms ? ST_SEL_DR : ST_RTI;
      default:   nxt = ST_TLR;
    endcase
    return nxt;
  endfunction

endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
  import tap_pkg::*;
(
  input  logic        tck_i,
  input  logic        rst_ni,
  input  logic        sys_rst_i,
  input  logic        tms_i,
  output tap_state_e  state_o,
  output tap_strobe_t strobe_o,
  output logic        in_tlr_o
);

  tap_state_e state_q;

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni)        state_q <= ST_TLR;
    else if (sys_rst_i) state_q <= ST_TLR;
    else                state_q <= tap_next(state_q, tms_i);
  end

  always_comb begin
    strobe_o.cap_dr = (state_q == ST_CAP_DR);
    strobe_o.sh_dr  = (state_q == ST_SH_DR);
    strobe_o.upd_dr = (state_q == ST_UPD_DR);
    strobe_o.cap_ir = (state_q == ST_CAP_IR);
    strobe_o.sh_ir  = (state_q == ST_SH_IR);
    strobe_o.upd_ir = (state_q == ST_UPD_IR);
  end

  assign in_tlr_o = (state_q == ST_TLR);
  assign state_o  = state_q;

endmodule

// File: rtl/tap_ir.sv
module tap_ir #(
  parameter int unsigned       IR_W        = 5,
  parameter logic [IR_W-1:0]   CAPTURE_VAL = IR_W'(1),
  parameter logic [IR_W-1:0]   RESET_OP    = IR_W'(1)
) (
  input  logic            tck_i,
  input  logic            rst_ni,
  input  logic            capture_i,
  input  logic            shift_i,
  input  logic            update_i,
  input  logic            reset_op_i,
  input  logic            tdi_i,
  output logic            shift_lsb_o,
  output logic [IR_W-1:0] instr_o
);

  logic [IR_W-1:0] sh_q;
  logic [IR_W-1:0] upd_q;

  // shift stage: parallel capture, serial shift toward bit 0
  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni)        sh_q <= '0;
    else if (capture_i) sh_q <= CAPTURE_VAL;
    else if (shift_i)   sh_q <= {tdi_i, sh_q[IR_W-1:1]};
  end

  // output stage
  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni)         upd_q <= RESET_OP;
    else if (reset_op_i) upd_q <= RESET_OP;
    else if (update_i)   upd_q <= sh_q;
  end

  // reset state overrides at once, without waiting for the reload edge
  assign instr_o     = reset_op_i ? RESET_OP : upd_q;
  assign shift_lsb_o = sh_q[0];

endmodule

// File: rtl/tap_decode.sv
module tap_decode #(
  parameter int unsigned     IR_W      = 5,
  parameter logic [IR_W-1:0] OP_IDCODE = IR_W'(1),
  parameter logic [IR_W-1:0] OP_SAMPLE = IR_W'(2),
  parameter logic [IR_W-1:0] OP_EXTEST = IR_W'(0),
  parameter logic [IR_W-1:0] OP_BYPASS = '1
) (
  input  logic [IR_W-1:0] instr_i,
  output logic            sel_idcode_o,
  output logic            sel_sample_o,
  output logic            sel_extest_o,
  output logic            sel_bypass_o
);

  logic hit_id, hit_smp, hit_ext, hit_byp;

  always_comb begin
    hit_id  = (instr_i == OP_IDCODE);
    hit_smp = (instr_i == OP_SAMPLE);
    hit_ext = (instr_i == OP_EXTEST);
    hit_byp = (instr_i == OP_BYPASS);
    sel_idcode_o = hit_id;
    sel_sample_o = hit_smp;
    sel_extest_o = hit_ext;
    // unassigned codes fall through to bypass
    sel_bypass_o = hit_byp | ~(hit_id | hit_smp | hit_ext);
  end

endmodule

// File: rtl/tap_tdo.sv
module tap_tdo (
  input  logic tck_i,
  input  logic rst_ni,
  input  logic sh_ir_i,
  input  logic sh_dr_i,
  input  logic ir_lsb_i,
  input  logic dr_tdo_i,
  output logic tdo_o,
  output logic tdo_en_o
);

  always_ff @(negedge tck_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tdo_o    <= 1'b0;
      tdo_en_o <= 1'b0;
    end else begin
      tdo_en_o <= sh_ir_i | sh_dr_i;
      tdo_o    <= (sh_ir_i & ir_lsb_i) | (sh_dr_i & dr_tdo_i);
    end
  end

endmodule

// File: rtl/tap_ctrl.sv
module tap_ctrl
  import tap_pkg::*;
#(
  parameter int unsigned     IR_W      = 5,
  parameter logic [IR_W-1:0] OP_IDCODE = IR_W'(1),
  parameter logic [IR_W-1:0] OP_SAMPLE = IR_W'(2),
  parameter logic [IR_W-1:0] OP_EXTEST = IR_W'(0),
  parameter logic [IR_W-1:0] OP_BYPASS = '1
) (
  input  logic            tck_i,
  input  logic            rst_ni,
  input  logic            sys_rst_i,
  input  logic            tms_i,
  input  logic            tdi_i,
  input  logic            dr_tdo_i,
  output logic            tdo_o,
  output logic            tdo_en_o,
  output logic [3:0]      state_o,
  output logic [IR_W-1:0] instr_o,
  output logic            sel_idcode_o,
  output logic            sel_sample_o,
  output logic            sel_extest_o,
  output logic            sel_bypass_o,
  output logic            capture_dr_o,
  output logic            shift_dr_o,
  output logic            update_dr_o,
  output logic            capture_ir_o,
  output logic            shift_ir_o,
  output logic            update_ir_o
);

  // two low bits 01, rest zero
  localparam logic [IR_W-1:0] IR_CAPTURE = IR_W'(1);

  tap_state_e  state;
  tap_strobe_t strb;
  logic        in_tlr;
  logic        ir_lsb;
  logic [IR_W-1:0] instr;

  tap_fsm u_fsm (
    .tck_i     (tck_i),
    .rst_ni    (rst_ni),
    .sys_rst_i (sys_rst_i),
    .tms_i     (tms_i),
    .state_o   (state),
    .strobe_o  (strb),
    .in_tlr_o  (in_tlr)
  );

  tap_ir #(
    .IR_W        (IR_W),
    .CAPTURE_VAL (IR_CAPTURE),
    .RESET_OP    (OP_IDCODE)
  ) u_ir (
    .tck_i       (tck_i),
    .rst_ni      (rst_ni),
    .capture_i   (strb.cap_ir),
    .shift_i     (strb.sh_ir),
    .update_i    (strb.upd_ir),
    .reset_op_i  (in_tlr),
    .tdi_i       (tdi_i),
    .shift_lsb_o (ir_lsb),
    .instr_o     (instr)
  );

  tap_decode #(
    .IR_W      (IR_W),
    .OP_IDCODE (OP_IDCODE),
    .OP_SAMPLE (OP_SAMPLE),
    .OP_EXTEST (OP_EXTEST),
    .OP_BYPASS (OP_BYPASS)
  ) u_dec (
    .instr_i      (instr),
    .sel_idcode_o (sel_idcode_o),
    .sel_sample_o (sel_sample_o),
    .sel_extest_o (sel_extest_o),
    .sel_bypass_o (sel_bypass_o)
  );

  tap_tdo u_tdo (
    .tck_i    (tck_i),
    .rst_ni   (rst_ni),
    .sh_ir_i  (strb.sh_ir),
    .sh_dr_i  (strb.sh_dr),
    .ir_lsb_i (ir_lsb),
    .dr_tdo_i (dr_tdo_i),
    .tdo_o    (tdo_o),
    .tdo_en_o (tdo_en_o)
  );

  assign state_o      = state;
  assign instr_o      = instr;
  assign capture_dr_o = strb.cap_dr;
  assign shift_dr_o   = strb.sh_dr;
  assign update_dr_o  = strb.upd_dr;
  assign capture_ir_o = strb.cap_ir;
  assign shift_ir_o   = strb.sh_ir;
  assign update_ir_o  = strb.upd_ir;

endmodule

// File: rtl/tap_ctrl_chk.sv
module tap_ctrl_chk
  import tap_pkg::*;
#(
  parameter int unsigned     IR_W      = 5,
  parameter logic [IR_W-1:0] OP_IDCODE = IR_W'(1)
) (
  input logic            tck_i,
  input logic            rst_ni,
  input logic            sys_rst_i,
  input logic            tms_i,
  input logic            tdo_o,
  input logic            tdo_en_o,
  input logic [3:0]      state_o,
  input logic [IR_W-1:0] instr_o,
  input logic            sel_idcode_o,
  input logic            sel_sample_o,
  input logic            sel_extest_o,
  input logic            sel_bypass_o,
  input logic            capture_dr_o,
  input logic            shift_dr_o,
  input logic            update_dr_o,
  input logic            capture_ir_o,
  input logic            shift_ir_o,
  input logic            update_ir_o
);

  logic [2:0] ones_q;

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni)            ones_q <= '0;
    else if (!tms_i)        ones_q <= '0;
    else if (ones_q != 3'd7) ones_q <= ones_q + 3'd1;
  end

  a_r2_sys_rst: assert property (@(posedge tck_i) disable iff (!rst_ni)
    sys_rst_i |=> (state_o == ST_TLR));

  a_r3_five_ones: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (tms_i && ones_q >= 3'd4) |=> (state_o == ST_TLR));

  a_r4_selir_exit: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (state_o == ST_SEL_IR && tms_i) |=> (state_o == ST_TLR));

  a_r4_capir_next: assert property (@(posedge tck_i) disable iff (!rst_ni)
    capture_ir_o |=> (shift_ir_o || state_o == ST_EX1_IR || state_o == ST_TLR));

  a_r5_tlr_idcode: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (state_o == ST_TLR) |-> (sel_idcode_o && instr_o == OP_IDCODE));

  a_r8_instr_hold: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (state_o != ST_UPD_IR) |=> (state_o == ST_TLR || $stable(instr_o)));

  a_r9_one_select: assert property (@(posedge tck_i) disable iff (!rst_ni)
    $countones({sel_idcode_o, sel_sample_o, sel_extest_o, sel_bypass_o}) == 1);

  a_r10_tdo_enable: assert property (@(posedge tck_i) disable iff (!rst_ni)
    tdo_en_o == (state_o == ST_SH_IR || state_o == ST_SH_DR));

  a_r10_tdo_idle: assert property (@(posedge tck_i) disable iff (!rst_ni)
    !tdo_en_o |-> !tdo_o);

  a_r11_strobe_excl: assert property (@(posedge tck_i) disable iff (!rst_ni)
    $onehot0({capture_dr_o, shift_dr_o, update_dr_o, capture_ir_o, shift_ir_o, update_ir_o}));

endmodule

bind tap_ctrl tap_ctrl_chk #(
  .IR_W      (IR_W),
  .OP_IDCODE (OP_IDCODE)
) u_chk (
  .tck_i        (tck_i),
  .rst_ni       (rst_ni),
  .sys_rst_i    (sys_rst_i),
  .tms_i        (tms_i),
  .tdo_o        (tdo_o),
  .tdo_en_o     (tdo_en_o),
  .state_o      (state_o),
  .instr_o      (instr_o),
  .sel_idcode_o (sel_idcode_o),
  .sel_sample_o (sel_sample_o),
  .sel_extest_o (sel_extest_o),
  .sel_bypass_o (sel_bypass_o),
  .capture_dr_o (capture_dr_o),
  .shift_dr_o   (shift_dr_o),
  .update_dr_o  (update_dr_o),
  .capture_ir_o (capture_ir_o),
  .shift_ir_o   (shift_ir_o),
  .update_ir_o  (update_ir_o)
);

// File: tb/tap_ctrl_bench.sv
module tap_ctrl_bench;

  logic tck = 1'b0;
  logic rst_n = 1'b0;
  logic sys_rst = 1'b0;
  logic tms = 1'b1;
  logic tdi = 1'b0;
  logic dr_tdo = 1'b0;

  logic       tdo, tdo_en;
  logic [3:0] state;
  logic [4:0] instr;
  logic       s_id, s_smp, s_ext, s_byp;
  logic       c_dr, sh_dr, u_dr, c_ir, sh_ir, u_ir;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [3:0] m_state;
  logic [4:0] m_sh, m_upd;
  logic       m_dr;
  logic [9:0] obs;

  always #5 tck = ~tck;

  tap_ctrl u_tap_ctrl (
    .tck_i(tck), .rst_ni(rst_n), .sys_rst_i(sys_rst), .tms_i(tms), .tdi_i(tdi),
    .dr_tdo_i(dr_tdo), .tdo_o(tdo), .tdo_en_o(tdo_en), .state_o(state), .instr_o(instr),
    .sel_idcode_o(s_id), .sel_sample_o(s_smp), .sel_extest_o(s_ext), .sel_bypass_o(s_byp),
    .capture_dr_o(c_dr), .shift_dr_o(sh_dr), .update_dr_o(u_dr),
    .capture_ir_o(c_ir), .shift_ir_o(sh_ir), .update_ir_o(u_ir)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  function automatic logic [3:0] succ(input logic [3:0] s, input logic t);
    case (s)
      4'd0:  return t ? 4'd0  : 4'd1;
      4'd1:  return t ? 4'd2  : 4'd1;
      4'd2:  return t ? 4'd9  : 4'd3;
      4'd3:  return t ? 4'd5  : 4'd4;
      4'd4:  return t ? 4'd5  : 4'd4;
      4'd5:  return t ? 4'd8  : 4'd6;
      4'd6:  return t ? 4'd7  : 4'd6;
      4'd7:  return t ? 4'd8  : 4'd4;
      4'd8:  return t ? 4'd2  : 4'd1;
      4'd9:  return t ? 4'd0  : 4'd10;
      4'd10: return t ? 4'd12 : 4'd11;
      4'd11: return t ? 4'd12 : 4'd11;
      4'd12: return t ? 4'd15 : 4'd13;
      4'd13: return t ? 4'd14 : 4'd13;
      4'd14: return t ? 4'd15 : 4'd11;
      default: return t ? 4'd2 : 4'd1;
    endcase
  endfunction

  function automatic logic [3:0] exp_sel(input logic [4:0] op);
    // {idcode, sample, extest, bypass}
    if (op == 5'b00001) return 4'b1000;
    if (op == 5'b00010) return 4'b0100;
    if (op == 5'b00000) return 4'b0010;
    return 4'b0001;
  endfunction

  function automatic logic [5:0] exp_strb(input logic [3:0] s);
    return {s == 4'd3, s == 4'd4, s == 4'd8, s == 4'd10, s == 4'd11, s == 4'd15};
  endfunction

  task automatic model_reset();
    m_state = 4'd0;
    m_sh    = 5'd0;
    m_upd   = 5'b00001;
    m_dr    = 1'b0;
  endtask

  task automatic check_outputs();
    check("R4 state", state, m_state);
    check("R11 strobes", {c_dr, sh_dr, u_dr, c_ir, sh_ir, u_ir}, exp_strb(m_state));
    check("R8 instr", instr, (m_state == 4'd0) ? 5'b00001 : m_upd);
    check("R9 selects", {s_id, s_smp, s_ext, s_byp},
          exp_sel((m_state == 4'd0) ? 5'b00001 : m_upd));
  endtask

  task automatic tick(input logic t, input logic d, input logic dr, input logic sr);
    logic exp_en, exp_do;
    @(negedge tck);
    #1;
    exp_en = (m_state == 4'd11) || (m_state == 4'd4);
    exp_do = (m_state == 4'd11) ? m_sh[0] : ((m_state == 4'd4) ? m_dr : 1'b0);
    check("R10 tdo_en", tdo_en, exp_en);
    check("R10 tdo", tdo, exp_do);
    if (m_state == 4'd11) obs = {tdo, obs[9:1]};
    tms = t; tdi = d; dr_tdo = dr; sys_rst = sr;
    m_dr = dr;
    @(posedge tck);
    if (m_state == 4'd10)      m_sh = 5'b00001;
    else if (m_state == 4'd11) m_sh = {d, m_sh[4:1]};
    if (m_state == 4'd0)       m_upd = 5'b00001;
    else if (m_state == 4'd15) m_upd = m_sh;
    m_state = sr ? 4'd0 : succ(m_state, t);
    #2;
    check_outputs();
  endtask

  // from run-idle/reset: enter Shift-IR, shift n bits, update, back to run-idle
  task automatic ir_scan(input logic [9:0] bits, input int n);
    tick(1'b0, 1'b0, 1'b0, 1'b0);
    tick(1'b1, 1'b0, 1'b0, 1'b0);
    tick(1'b1, 1'b0, 1'b0, 1'b0);
    tick(1'b0, 1'b0, 1'b0, 1'b0);
    tick(1'b0, 1'b0, 1'b0, 1'b0);
    obs = '0;
    for (int i = 0; i < n; i++) tick(i == n - 1, bits[i], 1'b0, 1'b0);
    tick(1'b1, 1'b0, 1'b0, 1'b0);
    tick(1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic load_op(input logic [4:0] op, input logic [3:0] sel_exp, input string tag);
    ir_scan({5'b0, op}, 5);
    check({tag, " instr"}, instr, op);
    check({tag, " select"}, {s_id, s_smp, s_ext, s_byp}, sel_exp);
  endtask

  initial begin
    #1500000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    model_reset();
    obs = '0;
    repeat (3) @(posedge tck);
    #2;
    // R1 / R5: reset state
    check("R1 state in reset", state, 4'd0);
    check("R1 instr in reset", instr, 5'b00001);
    check("R1 tdo idle in reset", {tdo, tdo_en}, 2'b00);
    check("R5 idcode select", s_id, 1'b1);
    @(negedge tck);
    #1 rst_n = 1'b1;
    @(posedge tck);
    #2;
    check_outputs();

    // R6 capture pattern appears first on tdo; R9 decode of each code
    load_op(5'b00010, 4'b0100, "R9 sample");
    check("R6 capture pattern out", obs[9:5], 5'b00001);
    load_op(5'b00000, 4'b0010, "R9 extest");
    load_op(5'b11111, 4'b0001, "R9 bypass");
    load_op(5'b00111, 4'b0001, "R9 unassigned");
    load_op(5'b10100, 4'b0001, "R9 unassigned2");
    load_op(5'b00001, 4'b1000, "R9 idcode");

    // R7: ten-bit scan, first five bits reappear on tdo, last five become the instruction
    ir_scan(10'b00010_10110, 10);
    check("R7 shifted-through bits", obs[9:5], 5'b10110);
    check("R6 capture first", obs[4:0], 5'b00001);
    check("R7 instr from last five", instr, 5'b00010);

    // R10: Shift-DR passes dr_tdo_i
    tick(1'b1, 1'b0, 1'b0, 1'b0);
    tick(1'b0, 1'b0, 1'b0, 1'b0);
    tick(1'b0, 1'b0, 1'b1, 1'b0);
    for (int i = 0; i < 6; i++) tick(1'b0, 1'b0, i[0], 1'b0);

    // R3: five ones from Shift-DR
    for (int i = 0; i < 5; i++) tick(1'b1, 1'b0, 1'b0, 1'b0);
    check("R3 five ones from shift-dr", state, 4'd0);
    check("R5 idcode after reset walk", instr, 5'b00001);

    // R3 from Pause-IR
    load_op(5'b00000, 4'b0010, "R9 extest again");
    tick(1'b1, 1'b0, 1'b0, 1'b0);
    tick(1'b1, 1'b0, 1'b0, 1'b0);
    tick(1'b0, 1'b0, 1'b0, 1'b0);
    tick(1'b1, 1'b0, 1'b0, 1'b0);
    tick(1'b0, 1'b0, 1'b0, 1'b0);
    check("R4 pause-ir reached", state, 4'd13);
    for (int i = 0; i < 5; i++) tick(1'b1, 1'b0, 1'b0, 1'b0);
    check("R3 five ones from pause-ir", state, 4'd0);

    // R2: sampled system reset in Shift-DR with a non-reset instruction
    load_op(5'b00010, 4'b0100, "R9 sample again");
    tick(1'b1, 1'b0, 1'b0, 1'b0);
    tick(1'b0, 1'b0, 1'b0, 1'b0);
    tick(1'b0, 1'b0, 1'b0, 1'b0);
    tick(1'b0, 1'b0, 1'b0, 1'b1);
    check("R2 sys reset state", state, 4'd0);
    check("R2 sys reset instr", instr, 5'b00001);
    tick(1'b0, 1'b0, 1'b0, 1'b0);

    // R1: asynchronous reset between edges, mid Shift-IR
    load_op(5'b00000, 4'b0010, "R9 extest third");
    tick(1'b1, 1'b0, 1'b0, 1'b0);
    tick(1'b1, 1'b0, 1'b0, 1'b0);
    tick(1'b0, 1'b0, 1'b0, 1'b0);
    tick(1'b0, 1'b0, 1'b0, 1'b0);
    tick(1'b0, 1'b1, 1'b0, 1'b0);
    #1 rst_n = 1'b0;
    #1;
    check("R1 async state", state, 4'd0);
    check("R1 async instr", instr, 5'b00001);
    check("R1 async tdo", {tdo, tdo_en}, 2'b00);
    check("R11 async strobes", {c_dr, sh_dr, u_dr, c_ir, sh_ir, u_ir}, 6'b0);
    @(negedge tck);
    @(negedge tck);
    #1 rst_n = 1'b1;
    model_reset();
    tms = 1'b0;
    @(posedge tck);
    #2;
    m_state = succ(4'd0, 1'b0);
    check_outputs();

    // random walk: R4, R7, R8, R9, R10, R11 against the model
    for (int i = 0; i < 6000; i++) begin
      logic t, d, dr, sr;
      t  = (($urandom % 5) < 2);
      d  = $urandom % 2;
      dr = $urandom % 2;
      sr = (($urandom % 300) == 0);
      tick(t, d, dr, sr);
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule